// File: doc/BRIEF.md
# Packet Lifetime Limit Counter

This block enforces a wide packet-count lifetime (soft and hard limits of up to `LIM_W` bits) using a narrow `CNT_W`-bit down counter plus a count of remaining rounds. Each time the counter's top bit clears while rounds remain, the top bit is set again in the same step. That adds half the counter range and uses up one round. The counter's start value is chosen so that it stays in the upper half of its range until the final round. The hard limit is therefore reached only when the counter reaches zero with no rounds left.

A configuration load takes a hard limit, a soft limit and an "unlimited" flag. A short loader sequence first validates the limits. It then derives the start value and the round count from the hard limit. Finally it works out at which remaining-round count and which counter value the soft point falls. That value always lies where the counter is actually held, never on the transient value it passes through at a re-arm. While the loader runs, `busy` is high and packets are not counted.

At run time every `pkt_valid` cycle counts one packet. Reaching the soft point gives a one-cycle pulse and a sticky flag. Reaching the hard point gives a one-cycle pulse, and the sticky `drop` output holds until the next accepted load. Counting stops after the hard point.

Top module: `plc_limiter`

## Requirements
- R1: After reset, `busy`, `cfg_err`, `soft_pulse`, `soft_seen`, `hard_pulse` and `drop` are 0, and packets cause no events until a configuration is loaded.
- R2: A `cfg_load` is accepted only while `busy` is 0. After an accepted load, `busy` is 1 for exactly 3 cycles for a valid finite configuration, and for 1 cycle for a rejected or unlimited one. A `cfg_load` while busy is ignored, and packets while busy are not counted.
- R3: A finite configuration with soft = 0, hard = 0 or soft >= hard is rejected. `cfg_err` becomes 1, nothing is counted and no events occur. The next accepted load clears `cfg_err`.
- R4: With `cfg_inf` = 1 the limits are ignored, `cfg_err` stays 0, and no packet produces any event.
- R5: `hard_pulse` is 1 for exactly the one cycle after the edge that counts packet number `hard`. `drop` becomes 1 at that same edge and stays 1 until the next accepted load. Later packets produce no pulse.
- R6: `soft_pulse` is 1 for exactly the one cycle after the edge that counts packet number `soft`. `soft_seen` becomes 1 at that edge and holds until the next accepted load. There is at most one soft pulse per load.
- R7: Limits above 2^(CNT_W-1) are reached exactly. They use re-arms, in which a counted packet at counter value 2^(CNT_W-1) with rounds remaining leaves the counter at 2^CNT_W-1.
- R8: An accepted `cfg_load` in the same cycle as a packet that would reach a limit wins. No pulse is produced, and `drop` and `soft_seen` are cleared.
- R9: Cycles with `pkt_valid` = 0 do not count and produce no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load request for a new configuration |
| cfg_hard | input | LIM_W | Hard packet limit |
| cfg_soft | input | LIM_W | Soft packet limit |
| cfg_inf | input | 1 | Unlimited lifetime: no counting, no events |
| pkt_valid | input | 1 | One packet counted per cycle when high |
| busy | output | 1 | Loader sequence in progress |
| cfg_err | output | 1 | Last loaded configuration was rejected |
| soft_pulse | output | 1 | One-cycle soft-limit event |
| soft_seen | output | 1 | Sticky soft-limit flag |
| hard_pulse | output | 1 | One-cycle hard-limit event |
| drop | output | 1 | Sticky hard-limit flag; traffic must be dropped |

## Verification
Two functions can coincide in one cycle: a new configuration load and the packet that would reach a limit of the old configuration. Another pair is a re-arm step and a soft point placed on the value just after it. The bench provokes the first by raising `cfg_load` together with `pkt_valid` on the packet that would reach the old hard limit. It then judges that no pulse appears and that `drop` and `soft_seen` read 0 while `busy` is 1. The second pair is covered by an exhaustive sweep over every soft limit below each hard limit in a narrow counter configuration. In that sweep the expected pulse cycle is computed by counting packets, never from the counter's internal layout.

// File: rtl/plc_pkg.sv
package plc_pkg;

   // Loader sequence states
   typedef enum logic [1:0] {
      LD_IDLE,
      LD_CHECK,
      LD_HARD,
      LD_SOFT
   } ld_state_e;

   // Cycles that busy is high for a valid finite configuration
   localparam int LOAD_CYCLES = 3;

endpackage

// File: rtl/plc_loader.sv
module plc_loader
   import plc_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int LIM_W = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_load,
   input  logic [LIM_W-1:0]         cfg_hard,
   input  logic [LIM_W-1:0]         cfg_soft,
   input  logic                     cfg_inf,
   output logic                     accept,
   output logic                     busy,
   output logic                     go,
   output logic                     cfg_err,
   output logic [CNT_W-1:0]         start_val,
   output logic [LIM_W-CNT_W+1:0]   rounds,
   output logic [CNT_W-1:0]         soft_val,
   output logic [LIM_W-CNT_W+1:0]   soft_rnd
);
   localparam int RND_W = LIM_W - CNT_W + 2;
   localparam int SH    = CNT_W - 1;
   localparam logic [LIM_W-1:0] HALF = {{(LIM_W-1){1'b0}}, 1'b1} << SH;
   localparam logic [LIM_W-1:0] ONE  = {{(LIM_W-1){1'b0}}, 1'b1};

   ld_state_e        st_q;
   logic [LIM_W-1:0] hard_q, soft_q;
   logic             inf_q, err_q, bad_c;
   logic [RND_W-1:0] nh_q;
   logic [CNT_W-1:0] hs_q;
   logic [LIM_W-1:0] nh_est, nh_c, nh_w, hs_w, lo_c, d_c, e_c, sv_full;

   assign accept  = cfg_load && (st_q == LD_IDLE);
   assign busy    = (st_q != LD_IDLE);
   assign go      = (st_q == LD_SOFT);
   assign cfg_err = err_q;

   // Limit validation
   always_comb bad_c = !inf_q && ((soft_q == '0) || (hard_q == '0) || (soft_q >= hard_q));

   // Hard split: rounds one below the floor estimate so the counter starts in the upper half
   always_comb begin
      nh_est = hard_q >> SH;
      nh_c   = (nh_est != '0) ? (nh_est - ONE) : '0;
   end

   // Soft placement: round in which the soft point is held, and the value there
   always_comb begin
      nh_w = LIM_W'(nh_q);
      hs_w = LIM_W'(hs_q);
      lo_c = hs_w - HALF;
      d_c  = soft_q - lo_c;
      e_c  = '0;
      if ((nh_q != '0) && (soft_q > lo_c)) begin
         e_c = ((d_c - ONE) >> SH) + ONE;
         if (e_c > nh_w) e_c = nh_w;
      end
      sv_full = hs_w + (e_c << SH) - soft_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= LD_IDLE;
         hard_q <= '0;
         soft_q <= '0;
         inf_q  <= 1'b0;
         err_q  <= 1'b0;
         nh_q   <= '0;
         hs_q   <= '0;
      end else begin
         case (st_q)
            LD_IDLE: begin
               if (cfg_load) begin
                  hard_q <= cfg_hard;
                  soft_q <= cfg_soft;
                  inf_q  <= cfg_inf;
                  err_q  <= 1'b0;
                  st_q   <= LD_CHECK;
               end
            end
            LD_CHECK: begin
               if (inf_q || bad_c) begin
                  err_q <= bad_c;
                  st_q  <= LD_IDLE;
               end else begin
                  st_q  <= LD_HARD;
               end
            end
            LD_HARD: begin
               nh_q <= nh_c[RND_W-1:0];
               hs_q <= CNT_W'(hard_q - (nh_c << SH));
               st_q <= LD_SOFT;
            end
            default: st_q <= LD_IDLE;
         endcase
      end
   end

   assign start_val = hs_q;
   assign rounds    = nh_q;
   assign soft_val  = sv_full[CNT_W-1:0];
   assign soft_rnd  = nh_q - e_c[RND_W-1:0];

   // R2: an accepted load makes the block busy on the next cycle
   p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);
   // R3: a rejected configuration never reaches the counter
   p_err_no_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !go);
   // R6: soft compare value lies inside the counter range and is never zero
   p_soft_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> ((sv_full != '0) && (sv_full < (HALF << 1))));

endmodule

// File: rtl/plc_counter.sv
module plc_counter #(
   parameter int CNT_W = 32,
   parameter int LIM_W = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     halt,
   input  logic                     go,
   input  logic                     busy,
   input  logic                     pkt_valid,
   input  logic [CNT_W-1:0]         start_val,
   input  logic [LIM_W-CNT_W+1:0]   rounds,
   input  logic [CNT_W-1:0]         soft_val,
   input  logic [LIM_W-CNT_W+1:0]   soft_rnd,
   output logic                     soft_hit,
   output logic                     hard_hit,
   output logic                     armed
);
   localparam int RND_W = LIM_W - CNT_W + 2;
   localparam logic [CNT_W-1:0] TOP  = {1'b1, {(CNT_W-1){1'b0}}};
   localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q, sv_q, dec, nxt;
   logic [RND_W-1:0] rem_q, sr_q, rem_n;
   logic             armed_q, count_en, rearm;

   always_comb begin
      count_en = armed_q && pkt_valid && !halt && !busy;
      dec      = cnt_q - CNT_W'(1);
      // top bit just cleared with rounds left: set it again in the same step
      rearm    = cnt_q[CNT_W-1] && !dec[CNT_W-1] && (rem_q != '0);
      nxt      = rearm ? (dec | TOP) : dec;
      rem_n    = rearm ? (rem_q - RND_W'(1)) : rem_q;
      hard_hit = count_en && (nxt == '0) && (rem_n == '0);
      soft_hit = count_en && (nxt == sv_q) && (rem_n == sr_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         rem_q   <= '0;
         sv_q    <= '0;
         sr_q    <= '0;
         armed_q <= 1'b0;
      end else if (halt) begin
         armed_q <= 1'b0;
      end else if (go) begin
         cnt_q   <= start_val;
         rem_q   <= rounds;
         sv_q    <= soft_val;
         sr_q    <= soft_rnd;
         armed_q <= 1'b1;
      end else if (count_en) begin
         cnt_q <= nxt;
         rem_q <= rem_n;
         if (hard_hit) armed_q <= 1'b0;
      end
   end

   assign armed = armed_q;

   // R7: a counted packet at the half point with rounds left re-arms to all ones
   p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && (cnt_q == TOP) && (rem_q != '0)) |=> (cnt_q == FULL));
   // R2: the counter does not move while the loader is busy
   p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !go) |=> $stable(cnt_q));
   // R5: counting stops after the hard point
   p_stop_after_hard_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hard_hit |=> !armed_q);

endmodule

// File: rtl/plc_events.sv
module plc_events (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic soft_hit,
   input  logic hard_hit,
   output logic soft_pulse,
   output logic soft_seen,
   output logic hard_pulse,
   output logic drop
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soft_pulse <= 1'b0;
         soft_seen  <= 1'b0;
         hard_pulse <= 1'b0;
         drop       <= 1'b0;
      end else if (clear) begin
         soft_pulse <= 1'b0;
         soft_seen  <= 1'b0;
         hard_pulse <= 1'b0;
         drop       <= 1'b0;
      end else begin
         soft_pulse <= soft_hit && !soft_seen;
         soft_seen  <= soft_seen || soft_hit;
         hard_pulse <= hard_hit;
         drop       <= drop || hard_hit;
      end
   end

   // R5: drop holds until a load clears it
   p_drop_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (drop && !clear) |=> drop);
   // R5: hard event is a single-cycle pulse
   p_hard_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hard_pulse |=> !hard_pulse);
   // R6: once seen, no further soft pulse until a load
   p_soft_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_seen && !clear) |=> !soft_pulse);

endmodule

// File: rtl/plc_limiter.sv
module plc_limiter #(
   parameter int CNT_W = 32,
   parameter int LIM_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_load,
   input  logic [LIM_W-1:0] cfg_hard,
   input  logic [LIM_W-1:0] cfg_soft,
   input  logic             cfg_inf,
   input  logic             pkt_valid,
   output logic             busy,
   output logic             cfg_err,
   output logic             soft_pulse,
   output logic             soft_seen,
   output logic             hard_pulse,
   output logic             drop
);
   localparam int RND_W = LIM_W - CNT_W + 2;

   generate
      if (CNT_W < 4 || LIM_W <= CNT_W) begin : g_bad_widths
         $error("plc_limiter: CNT_W must be at least 4 and below LIM_W");
      end
   endgenerate

   logic             accept, go, soft_hit, hard_hit, armed;
   logic [CNT_W-1:0] start_val, soft_val;
   logic [RND_W-1:0] rounds, soft_rnd;

   plc_loader #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_loader (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_load  (cfg_load),
      .cfg_hard  (cfg_hard),
      .cfg_soft  (cfg_soft),
      .cfg_inf   (cfg_inf),
      .accept    (accept),
      .busy      (busy),
      .go        (go),
      .cfg_err   (cfg_err),
      .start_val (start_val),
      .rounds    (rounds),
      .soft_val  (soft_val),
      .soft_rnd  (soft_rnd)
   );

   plc_counter #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .halt      (accept),
      .go        (go),
      .busy      (busy),
      .pkt_valid (pkt_valid),
      .start_val (start_val),
      .rounds    (rounds),
      .soft_val  (soft_val),
      .soft_rnd  (soft_rnd),
      .soft_hit  (soft_hit),
      .hard_hit  (hard_hit),
      .armed     (armed)
   );

   plc_events u_events (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (accept),
      .soft_hit   (soft_hit),
      .hard_hit   (hard_hit),
      .soft_pulse (soft_pulse),
      .soft_seen  (soft_seen),
      .hard_pulse (hard_pulse),
      .drop       (drop)
   );

   // R3: a rejected configuration leaves the counter idle
   p_err_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !armed);
   // R8: a load in the cycle of a limit-reaching packet suppresses the event
   p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (!hard_pulse && !soft_pulse && !drop));

endmodule

// File: tb/plc_limiter_tb_top.sv
module plc_limiter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 6;
   localparam int LW = 16;
   localparam int HALF = 2 ** (CW - 1);
   localparam int WD_CYCLES = 190000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_load = 1'b0;
   logic [LW-1:0] cfg_hard = '0;
   logic [LW-1:0] cfg_soft = '0;
   logic cfg_inf = 1'b0;
   logic pkt_valid = 1'b0;
   logic busy, cfg_err, soft_pulse, soft_seen, hard_pulse, drop;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   plc_limiter #(.CNT_W(CW), .LIM_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_hard(cfg_hard),
      .cfg_soft(cfg_soft), .cfg_inf(cfg_inf), .pkt_valid(pkt_valid),
      .busy(busy), .cfg_err(cfg_err), .soft_pulse(soft_pulse),
      .soft_seen(soft_seen), .hard_pulse(hard_pulse), .drop(drop));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // starts and ends on a falling edge; one rising edge samples cfg_load
   task automatic load_cfg(input int h, input int s, input bit inf, input bit pv);
      cfg_hard  = LW'(h);
      cfg_soft  = LW'(s);
      cfg_inf   = inf;
      cfg_load  = 1'b1;
      pkt_valid = pv;
      @(negedge clk);
      cfg_load  = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic run_pkts(input int h, input int s, input bit gap);
      int acc = 0;
      int step = 0;
      bit v, fs, fh;
      string th;
      th = (h > HALF) ? "R7" : "R5";
      while (step < 3 * h + 10 && !(acc >= h && step >= h + 2)) begin
         v = gap ? (step % 3 != 2) : 1'b1;
         pkt_valid = v;
         @(negedge clk);
         fs = 1'b0;
         fh = 1'b0;
         if (v && acc < h) begin
            acc++;
            fs = (acc == s);
            fh = (acc == h);
         end
         chk(soft_pulse == fs, v ? "R6 soft_pulse" : "R9 soft_pulse idle", soft_pulse, fs);
         chk(hard_pulse == fh, v ? {th, " hard_pulse"} : "R9 hard_pulse idle", hard_pulse, fh);
         chk(drop == (acc >= h), {th, " drop"}, drop, acc >= h);
         chk(soft_seen == (acc >= s), "R6 soft_seen", soft_seen, acc >= s);
         step++;
      end
      pkt_valid = 1'b0;
   endtask

   task automatic run_case(input int h, input int s, input bit gap);
      load_cfg(h, s, 1'b0, 1'b1);
      // R2: three busy cycles, packets meanwhile not counted; R5 flags cleared by load
      chk(busy == 1'b1, "R2 busy c1", busy, 1);
      chk(drop == 1'b0, "R5 drop cleared", drop, 0);
      @(negedge clk);
      chk(busy == 1'b1, "R2 busy c2", busy, 1);
      @(negedge clk);
      chk(busy == 1'b1, "R2 busy c3", busy, 1);
      @(negedge clk);
      chk(busy == 1'b0, "R2 busy end", busy, 0);
      chk(cfg_err == 1'b0, "R3 err clear on valid load", cfg_err, 0);
      run_pkts(h, s, gap);
   endtask

   task automatic quiet_pkts(input int n, input string req);
      pkt_valid = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(soft_pulse == 1'b0, {req, " no soft"}, soft_pulse, 0);
         chk(hard_pulse == 1'b0, {req, " no hard"}, hard_pulse, 0);
         chk(drop == 1'b0, {req, " no drop"}, drop, 0);
      end
      pkt_valid = 1'b0;
   endtask

   task automatic err_case(input int h, input int s);
      load_cfg(h, s, 1'b0, 1'b0);
      chk(busy == 1'b1, "R2 busy reject c1", busy, 1);
      @(negedge clk);
      chk(busy == 1'b0, "R2 busy reject end", busy, 0);
      chk(cfg_err == 1'b1, "R3 cfg_err", cfg_err, 1);
      quiet_pkts(12, "R3");
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(cfg_err == 1'b0, "R1 cfg_err", cfg_err, 0);
      chk(soft_pulse == 1'b0, "R1 soft_pulse", soft_pulse, 0);
      chk(soft_seen == 1'b0, "R1 soft_seen", soft_seen, 0);
      chk(hard_pulse == 1'b0, "R1 hard_pulse", hard_pulse, 0);
      chk(drop == 1'b0, "R1 drop", drop, 0);
      quiet_pkts(6, "R1");

      // R3: rejected configurations
      err_case(0, 0);
      err_case(5, 0);
      err_case(0, 3);
      err_case(7, 7);
      err_case(5, 9);

      // R4: unlimited, even with limits that would be rejected
      load_cfg(3, 9, 1'b1, 1'b0);
      chk(busy == 1'b1, "R4 busy c1", busy, 1);
      @(negedge clk);
      chk(busy == 1'b0, "R4 busy end", busy, 0);
      chk(cfg_err == 1'b0, "R4 no err", cfg_err, 0);
      quiet_pkts(150, "R4");

      // exhaustive small sweep: every soft below every hard
      for (int h = 2; h <= 48; h++)
         for (int s = 1; s < h; s++)
            run_case(h, s, h[0]);

      // multi-round sweep with soft at boundaries near re-arm points (R7)
      for (int h = 49; h <= 160; h += 3) begin
         run_case(h, 1, 1'b0);
         run_case(h, h - 1, 1'b0);
         run_case(h, h / 2, h[0]);
         run_case(h, h - HALF, 1'b0);
         run_case(h, (h % HALF) + 1, 1'b0);
      end
      run_case(1000, 500, 1'b0);
      run_case(2049, 2048, 1'b1);

      // R2: second load while busy is ignored
      load_cfg(10, 4, 1'b0, 1'b0);
      cfg_hard = LW'(2);
      cfg_soft = LW'(1);
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      wait_idle();
      run_pkts(10, 4, 1'b0);

      // R8: load together with the packet reaching the old hard limit
      load_cfg(5, 2, 1'b0, 1'b0);
      wait_idle();
      pkt_valid = 1'b1;
      repeat (4) @(negedge clk);
      chk(soft_seen == 1'b1, "R8 pre soft_seen", soft_seen, 1);
      chk(drop == 1'b0, "R8 pre drop", drop, 0);
      cfg_hard = LW'(9);
      cfg_soft = LW'(3);
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load  = 1'b0;
      pkt_valid = 1'b0;
      chk(hard_pulse == 1'b0, "R8 hard_pulse", hard_pulse, 0);
      chk(drop == 1'b0, "R8 drop", drop, 0);
      chk(soft_seen == 1'b0, "R8 soft_seen", soft_seen, 0);
      chk(busy == 1'b1, "R8 busy", busy, 1);
      wait_idle();
      run_pkts(9, 3, 1'b0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule